// File: doc/BRIEF.md
# Programmable-Priority Highest-Pending Resolver

This block sits beside an interrupt controller. Given which sources are pending, which are enabled and which are steered to the fast-interrupt (FIQ) class rather than the normal (IRQ) class, it finds the winning source of each class. The order of preference is not fixed by source number. Software fills a table of 40 priority slots, and each slot names the source that holds that level. Slot 0 is the most urgent.

The two winners are reported together in one registered 32-bit word. Each half has its own found flag. The slot table is written and read through a simple indexed port. The search runs over the whole table every cycle, so the result word always follows the inputs with one register of delay.

Top module: `prio_resolver`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `hp_word` is 0x003F003F and every slot reads back as zero (all slots invalid).
- R2: A write stores only data bit 31 (slot valid) and bits 5:0 (source ID). A read of that slot returns those two fields at the same positions, with bits 30:6 zero. `slot_rdata` follows `slot_sel` combinationally.
- R3: A slot takes part in the search only when its valid bit is set and its source ID is below 40.
- R4: A source qualifies for a class only when it is pending, enabled, and steered to that class (`src_fiq` bit 1 means FIQ, 0 means IRQ).
- R5: Within each class, the qualifying slot with the lowest index wins. The two classes are resolved independently.
- R6: Result layout: bit 31 is the IRQ found flag, bits 21:16 are the IRQ winner ID, bit 15 is the FIQ found flag, and bits 5:0 are the FIQ winner ID.
- R7: A class with no qualifying slot reports flag 0 and ID 0x3F in its half.
- R8: Result bits 30:22 and 14:6 are always zero.
- R9: `hp_word` after a clock edge reflects the source vectors present at that edge and the slot contents held before it. A slot write therefore shows in `hp_word` one edge later than the write itself.
- R10: A source listed in several slots is ranked by the lowest slot it occupies.
- R11: A write with `slot_sel` of 40 or more changes no slot, and a read at such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | 40 | Pending flag per source |
| src_en | input | 40 | Enable flag per source |
| src_fiq | input | 40 | Class steering per source, 1 = FIQ, 0 = IRQ |
| slot_we | input | 1 | Write strobe for the slot selected by `slot_sel` |
| slot_sel | input | 6 | Slot index for write and read |
| slot_wdata | input | 32 | Write data: bit 31 valid, bits 5:0 source ID |
| slot_rdata | output | 32 | Read-back of the selected slot |
| hp_word | output | 32 | Registered packed winners of both classes |

## Verification
A slot rewrite and the search can happen in the same cycle. This includes rewriting the slot that currently wins while its source stays pending. The random phase writes slots nearly every other cycle while the source vectors keep changing. The search must still use the table as it stood before the write edge.

The reference model settles each cycle in a fixed order. It resolves with the old table first, then applies the write. Its output is compared with `hp_word` one edge later. Targeted sequences set up duplicate entries, out-of-range IDs and out-of-range slot indices, and check the resulting word against hand-computed constants.

// File: rtl/prio_resolver_pkg.sv
package prio_resolver_pkg;

    localparam int ID_W = 6;
    localparam logic [ID_W-1:0] NONE_ID = '1;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] src;
    } slot_t;

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] src;
    } pick_t;

    localparam pick_t EMPTY_PICK = '{found: 1'b0, src: NONE_ID};

    function automatic logic [31:0] pack_word(input pick_t irq, input pick_t fiq);
        return {irq.found, 9'b0, irq.src, fiq.found, 9'b0, fiq.src};
    endfunction

endpackage

// File: rtl/prio_slot_bank.sv
module prio_slot_bank
    import prio_resolver_pkg::*;
#(
    parameter int NSLOT = 40,
    parameter int SEL_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output slot_t [NSLOT-1:0]       slots
);

    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NSLOT - 1);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (we && sel == SEL_W'(g)) begin
                slots[g] <= '{valid: wdata[31], src: wdata[ID_W-1:0]};
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel <= LAST_SEL) begin
            rdata = {slots[sel].valid, {(31-ID_W){1'b0}}, slots[sel].src};
        end
    end

endmodule

// File: rtl/prio_class_search.sv
module prio_class_search
    import prio_resolver_pkg::*;
#(
    parameter int NSRC     = 40,
    parameter int NSLOT    = 40,
    parameter bit FIQ_SIDE = 1'b0
) (
    input  slot_t [NSLOT-1:0] slots,
    input  logic [NSRC-1:0]   src_pend,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   src_fiq,
    output pick_t             pick
);

    localparam logic [ID_W-1:0] SRC_LIM = ID_W'(NSRC - 1);

    logic [NSRC-1:0] live;
    assign live = src_pend & src_en & (FIQ_SIDE ? src_fiq : ~src_fiq);

    // Walk from the least urgent slot upward so the lowest index is applied last.
    always_comb begin
        pick = EMPTY_PICK;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slots[s].valid && slots[s].src <= SRC_LIM) begin
                if (live[slots[s].src]) begin
                    pick = '{found: 1'b1, src: slots[s].src};
                end
            end
        end
    end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_resolver_pkg::*;
#(
    parameter int NSRC  = 40,
    parameter int NSLOT = 40,
    parameter int SEL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_pend,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   src_fiq,
    input  logic              slot_we,
    input  logic [SEL_W-1:0]  slot_sel,
    input  logic [31:0]       slot_wdata,
    output logic [31:0]       slot_rdata,
    output logic [31:0]       hp_word
);

    localparam int NCLASS = 2;  // index 0 = IRQ, 1 = FIQ

    slot_t [NSLOT-1:0] slots;
    pick_t [NCLASS-1:0] picks;

    prio_slot_bank #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (slot_we),
        .sel   (slot_sel),
        .wdata (slot_wdata),
        .rdata (slot_rdata),
        .slots (slots)
    );

    for (genvar c = 0; c < NCLASS; c++) begin : g_class
        prio_class_search #(
            .NSRC     (NSRC),
            .NSLOT    (NSLOT),
            .FIQ_SIDE (c == 1)
        ) u_search (
            .slots    (slots),
            .src_pend (src_pend),
            .src_en   (src_en),
            .src_fiq  (src_fiq),
            .pick     (picks[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_word <= pack_word(EMPTY_PICK, EMPTY_PICK);
        end else begin
            hp_word <= pack_word(picks[0], picks[1]);
        end
    end

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int NSRC = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_pend,
    input logic [NSRC-1:0] src_en,
    input logic [NSRC-1:0] src_fiq,
    input logic [31:0]     slot_rdata,
    input logic [31:0]     hp_word
);

    localparam logic [5:0] SRC_LIM = 6'(NSRC - 1);

    logic [NSRC-1:0] live_irq_q, live_fiq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_irq_q <= '0;
            live_fiq_q <= '0;
        end else begin
            live_irq_q <= src_pend & src_en & ~src_fiq;
            live_fiq_q <= src_pend & src_en & src_fiq;
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) hp_word[30:22] == '0 && hp_word[14:6] == '0); // R8
    AST_IRQ_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n) !hp_word[31] |-> hp_word[21:16] == 6'h3F); // R7
    AST_FIQ_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n) !hp_word[15] |-> hp_word[5:0] == 6'h3F); // R7
    AST_IRQ_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n) hp_word[31] |-> hp_word[21:16] <= SRC_LIM); // R3
    AST_FIQ_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n) hp_word[15] |-> hp_word[5:0] <= SRC_LIM); // R3
    AST_IRQ_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n) (hp_word[31] && hp_word[21:16] <= SRC_LIM) |-> live_irq_q[hp_word[21:16]]); // R4
    AST_FIQ_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n) (hp_word[15] && hp_word[5:0] <= SRC_LIM) |-> live_fiq_q[hp_word[5:0]]); // R4
    AST_NO_LIVE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (live_irq_q == '0) |-> !hp_word[31]); // R9
    AST_RDATA_MASK: assert property (@(posedge clk) disable iff (!rst_n) slot_rdata[30:6] == '0); // R2

endmodule

bind prio_resolver prio_resolver_chk #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pend   (src_pend),
    .src_en     (src_en),
    .src_fiq    (src_fiq),
    .slot_rdata (slot_rdata),
    .hp_word    (hp_word)
);

// File: tb/tb_prio_resolver.sv
`timescale 1ns/1ps
module tb_prio_resolver;

    localparam int NSRC = 40;
    localparam int NSLOT = 40;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_pend, src_en, src_fiq;
    logic            slot_we;
    logic [5:0]      slot_sel;
    logic [31:0]     slot_wdata;
    logic [31:0]     slot_rdata;
    logic [31:0]     hp_word;

    always #2.5 clk = ~clk;

    prio_resolver dut (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
        .src_fiq(src_fiq), .slot_we(slot_we), .slot_sel(slot_sel),
        .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .hp_word(hp_word)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // Behavioural table: valid flag and source ID per slot.
    bit m_valid [NSLOT];
    int m_src   [NSLOT];

    function automatic logic [31:0] model_word();
        int irq_w = -1;
        int fiq_w = -1;
        logic [31:0] w;
        for (int s = 0; s < NSLOT; s++) begin
            if (m_valid[s] && m_src[s] < NSRC) begin
                if (src_pend[m_src[s]] && src_en[m_src[s]]) begin
                    if (src_fiq[m_src[s]] && fiq_w < 0) fiq_w = m_src[s];
                    if (!src_fiq[m_src[s]] && irq_w < 0) irq_w = m_src[s];
                end
            end
        end
        w = 32'h003F003F;
        if (irq_w >= 0) begin w[31] = 1'b1; w[21:16] = 6'(irq_w); end
        if (fiq_w >= 0) begin w[15] = 1'b1; w[5:0] = 6'(fiq_w); end
        return w;
    endfunction

    function automatic logic [31:0] model_read(int sel);
        if (sel >= NSLOT) return 32'h0;
        return {m_valid[sel], 25'b0, 6'(m_src[sel])};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: resolve with the old table, apply the write, compare after the edge.
    task automatic tick();
        logic [31:0] exp_w;
        exp_w = model_word();
        if (slot_we && slot_sel < NSLOT) begin
            m_valid[slot_sel] = slot_wdata[31];
            m_src[slot_sel]   = int'(slot_wdata[5:0]);
        end
        @(posedge clk);
        @(negedge clk);
        check(cur_req, "hp_word", hp_word, exp_w);
        check(cur_req, "slot_rdata", slot_rdata, model_read(int'(slot_sel)));
        check("R8", "reserved bits", hp_word & 32'h7FC0_7FC0, 32'h0);
    endtask

    task automatic wr(input logic [5:0] sel, input logic [31:0] data);
        slot_sel = sel; slot_wdata = data; slot_we = 1'b1;
        tick();
        slot_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_pend = '0; src_en = '0; src_fiq = '0;
        slot_we = 1'b0; slot_sel = '0; slot_wdata = '0;
        for (int s = 0; s < NSLOT; s++) begin m_valid[s] = 0; m_src[s] = 0; end
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1", "reset hp_word", hp_word, 32'h003F003F);
        for (int s = 0; s < NSLOT; s++) begin
            slot_sel = 6'(s);
            #0.1;
            check("R1", "reset slot", slot_rdata, 32'h0);
        end
        slot_sel = '0;
        rst_n = 1'b1;
        tick();

        // R2: masked write and read-back
        cur_req = "R2";
        wr(6'd3, 32'hFFFF_FFFF);
        check("R2", "masked readback", slot_rdata, 32'h8000003F);

        // R3: out-of-range ID and invalid slot are ignored
        cur_req = "R3";
        src_pend = '1; src_en = '1; src_fiq = '0;
        tick();
        check("R3", "id 63 ignored", hp_word, 32'h003F003F);
        wr(6'd1, 32'h0000_0005);
        tick();
        check("R3", "invalid slot ignored", hp_word, 32'h003F003F);

        // R6: both halves found
        cur_req = "R6";
        wr(6'd0, 32'h8000_0007);
        src_fiq[12] = 1'b1;
        wr(6'd2, 32'h8000_000C);
        tick();
        check("R6", "both winners", hp_word, 32'h8007800C);

        // R7: IRQ half empty
        cur_req = "R7";
        wr(6'd5, 32'h8000_0007);
        src_en[7] = 1'b0;
        tick();
        check("R7", "irq empty", hp_word, 32'h003F800C);

        // R5: independent classes, lower slot wins
        cur_req = "R5";
        wr(6'd4, 32'h8000_0009);
        tick();
        check("R5", "irq slot4 fiq slot2", hp_word, 32'h8009800C);

        // R10: duplicate source, lowest slot governs
        cur_req = "R10";
        src_en[7] = 1'b1; src_fiq[7] = 1'b1;
        tick();
        check("R10", "dup src 7 at slot0", hp_word, 32'h80098007);

        // R11: out-of-range slot index
        cur_req = "R11";
        wr(6'd45, 32'h8000_0001);
        check("R11", "read idx 45", slot_rdata, 32'h0);
        tick();
        check("R11", "no aliasing", hp_word, 32'h80098007);

        // R9: one-edge latency on inputs
        cur_req = "R9";
        src_pend = '0;
        tick();
        check("R9", "cleared after one edge", hp_word, 32'h003F003F);

        // R4/R5: random traffic, slot writes racing the search
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            src_pend = {$urandom, $urandom} [NSRC-1:0];
            src_en   = {$urandom, $urandom} [NSRC-1:0] | {$urandom, $urandom} [NSRC-1:0];
            src_fiq  = {$urandom, $urandom} [NSRC-1:0];
            slot_sel = 6'($urandom);
            slot_wdata = {($urandom % 4) != 0, 25'($urandom), 6'($urandom % 48)};
            slot_we = $urandom % 2;
            tick();
        end
        slot_we = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule